// File: doc/BRIEF.md
# Register File with One-Instruction Load Delay

This block is the general-purpose register file of a small pipelined integer core. It holds a parameterised number of registers of parameterised width, 32 by 32 bits by default. Two read ports return contents combinationally, and one direct write port updates a register at the clock edge. Register zero is hard-wired: it always reads as zero, and nothing can write it.

Load results do not go straight into the array. A schedule-load request places a target index, a value and a bit mask into a single pending slot. The slot is merged into its target at the next slot-advance event. A slot-advance event is a cycle in which the retire strobe is high, the schedule-load strobe is high, or both. On that event the pending load commits first, and then the slot takes the new request or becomes empty. Only the bits selected by the mask change in the target. The other bits keep their previous contents, so byte and halfword loads merge into a wider register. The slot is never forwarded to the read ports. The issuing logic must account for the one-instruction delay itself.

Top module: `dlrf_top`

## Requirements
- R1: Both read ports return zero whenever their address is 0, whatever writes or loads were aimed at register 0.
- R2: A direct write (`wr_en`=1) to a nonzero address is visible on the read ports from the next cycle on. A direct write to address 0 is discarded.
- R3: A cycle with `rst`=1 clears every register to zero and empties the pending slot. In the cycle after reset, every address reads zero.
- R4: A scheduled load does not change any read result in the cycle it is scheduled or in any later cycle before the next slot-advance event. No read port bypasses the pending slot.
- R5: On commit, each target bit whose mask bit is 1 takes the pending value bit, and each target bit whose mask bit is 0 keeps its old contents.
- R6: A schedule-load (`ld_en`=1) with or without `retire` first commits the previously pending load. It then replaces the slot with the new target, value and mask.
- R7: A `retire` pulse with `ld_en`=0 commits the pending load and empties the slot. A second such pulse writes nothing.
- R8: A load whose target is 0 is an empty slot. Its commit changes no register, whatever its value and mask.
- R9: When a direct write and a commit reach the same register in one cycle, the direct write is applied first and the masked merge is applied on top of it. Result = (wr_data & ~mask) | (value & mask).
- R10: The two read ports are independent. Each returns the contents of its own address in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_addr_a | input | 5 | Read port A address |
| rd_data_a | output | 32 | Read port A data, combinational |
| rd_addr_b | input | 5 | Read port B address |
| rd_data_b | output | 32 | Read port B data, combinational |
| wr_en | input | 1 | Direct write enable |
| wr_addr | input | 5 | Direct write address |
| wr_data | input | 32 | Direct write data |
| ld_en | input | 1 | Schedule a new load into the pending slot |
| ld_target | input | 5 | Target register of the scheduled load |
| ld_value | input | 32 | Value of the scheduled load |
| ld_mask | input | 32 | Bit mask of the scheduled load, 1 = bit is replaced |
| retire | input | 1 | Instruction retire strobe, advances the pending slot |

## Verification
A direct write and the commit of the pending load can land on the same register in the same cycle.

The directed case provokes this collision deliberately:
- A partial load to one register is scheduled.
- In the next cycle, a direct write to that register is issued together with a retire pulse.
- The read in the following cycle must show the write data with the masked load bits laid over it, as a fixed value worked out by hand.

The random phase drives writes, schedules and retires independently, so many more such collisions arise. There, every read is judged against a bench model that applies the write before the merge.

// File: rtl/dlrf_pkg.sv
package dlrf_pkg;
  localparam int DEF_DATA_W   = 32;
  localparam int DEF_NUM_REGS = 32;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/dlrf_pending.sv
module dlrf_pending #(
  parameter int DATA_W = 32,
  parameter int AW     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  input  logic              ld_en,
  input  logic [AW-1:0]     ld_target,
  input  logic [DATA_W-1:0] ld_value,
  input  logic [DATA_W-1:0] ld_mask,
  output logic [AW-1:0]     pend_tgt,
  output logic [DATA_W-1:0] pend_val,
  output logic [DATA_W-1:0] pend_mask,
  output logic              commit
);
  // Slot holding the load awaiting the next advance event
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_tgt  <= '0;
      pend_val  <= '0;
      pend_mask <= '0;
    end else if (advance) begin
      if (ld_en) begin
        pend_tgt  <= ld_target;
        pend_val  <= ld_value;
        pend_mask <= ld_mask;
      end else begin
        pend_tgt  <= '0;
        pend_val  <= '0;
        pend_mask <= '0;
      end
    end
  end

  // Index zero marks an empty slot
  assign commit = advance && (pend_tgt != '0);
endmodule

// File: rtl/dlrf_entry.sv
module dlrf_entry #(
  parameter int DATA_W = 32,
  parameter int AW     = 5,
  parameter int IDX    = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              commit,
  input  logic [AW-1:0]     pend_tgt,
  input  logic [DATA_W-1:0] pend_val,
  input  logic [DATA_W-1:0] pend_mask,
  output logic [DATA_W-1:0] q
);
  localparam logic [AW-1:0] MY_IDX = AW'(IDX);

  logic [DATA_W-1:0] base;
  logic [DATA_W-1:0] next_q;

  always_comb begin
    base = (wr_en && (wr_addr == MY_IDX)) ? wr_data : q;
    if (commit && (pend_tgt == MY_IDX))
      next_q = (base & ~pend_mask) | (pend_val & pend_mask);
    else
      next_q = base;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= next_q;
  end
endmodule

// File: rtl/dlrf_read_port.sv
module dlrf_read_port #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 32,
  parameter int AW       = 5
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
  input  logic [AW-1:0]                   addr,
  output logic [DATA_W-1:0]               data
);
  always_comb begin
    data = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (addr == AW'(i)) data = regs[i];
  end
endmodule

// File: rtl/dlrf_top.sv
module dlrf_top
  import dlrf_pkg::*;
#(
  parameter int DATA_W   = DEF_DATA_W,
  parameter int NUM_REGS = DEF_NUM_REGS,
  localparam int AW      = idx_width(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     rd_addr_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [AW-1:0]     rd_addr_b,
  output logic [DATA_W-1:0] rd_data_b,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ld_en,
  input  logic [AW-1:0]     ld_target,
  input  logic [DATA_W-1:0] ld_value,
  input  logic [DATA_W-1:0] ld_mask,
  input  logic              retire
);
  logic                            advance;
  logic                            commit;
  logic [AW-1:0]                   pend_tgt;
  logic [DATA_W-1:0]               pend_val;
  logic [DATA_W-1:0]               pend_mask;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;

  assign advance = retire || ld_en;

  dlrf_pending #(.DATA_W(DATA_W), .AW(AW)) u_pend (
    .clk(clk), .rst(rst), .advance(advance), .ld_en(ld_en),
    .ld_target(ld_target), .ld_value(ld_value), .ld_mask(ld_mask),
    .pend_tgt(pend_tgt), .pend_val(pend_val), .pend_mask(pend_mask),
    .commit(commit)
  );

  // Entry zero is a constant; the others are storage
  assign regs[0] = '0;

  for (genvar g = 1; g < NUM_REGS; g++) begin : g_entry
    dlrf_entry #(.DATA_W(DATA_W), .AW(AW), .IDX(g)) u_entry (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .commit(commit), .pend_tgt(pend_tgt),
      .pend_val(pend_val), .pend_mask(pend_mask), .q(regs[g])
    );
  end

  dlrf_read_port #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .AW(AW)) u_rd_a (
    .regs(regs), .addr(rd_addr_a), .data(rd_data_a)
  );

  dlrf_read_port #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .AW(AW)) u_rd_b (
    .regs(regs), .addr(rd_addr_b), .data(rd_data_b)
  );
endmodule

// File: rtl/dlrf_checker.sv
module dlrf_checker #(
  parameter int DATA_W = 32,
  parameter int AW     = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [AW-1:0]     rd_addr_a,
  input logic [DATA_W-1:0] rd_data_a,
  input logic [AW-1:0]     rd_addr_b,
  input logic [DATA_W-1:0] rd_data_b,
  input logic              wr_en,
  input logic [AW-1:0]     wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              ld_en,
  input logic              retire
);
  // R1 on port A
  a_r1_zero_port_a: assert property (@(posedge clk) disable iff (rst)
    (rd_addr_a == '0) |-> (rd_data_a == '0));

  // R1 on port B
  a_r1_zero_port_b: assert property (@(posedge clk) disable iff (rst)
    (rd_addr_b == '0) |-> (rd_data_b == '0));

  // R3: the cycle after reset reads zero everywhere
  a_r3_reset_clears: assert property (@(posedge clk)
    rst |=> (rd_data_a == '0 && rd_data_b == '0));

  // R2: a plain write is readable next cycle
  a_r2_write_visible: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != '0 && !ld_en && !retire)
      ##1 (rd_addr_a == $past(wr_addr)) |-> (rd_data_a == $past(wr_data)));

  // R4: without write or advance, a read does not change
  a_r4_no_bypass: assert property (@(posedge clk) disable iff (rst)
    (!rst && !wr_en && !ld_en && !retire)
      ##1 $stable(rd_addr_b) |-> $stable(rd_data_b));
endmodule

bind dlrf_top dlrf_checker #(.DATA_W(DATA_W), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
  .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .ld_en(ld_en), .retire(retire)
);

// File: tb/tb_dlrf_top.sv
module tb_dlrf_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  rd_addr_a = '0, rd_addr_b = '0;
  logic [31:0] rd_data_a, rd_data_b;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        ld_en = 1'b0;
  logic [4:0]  ld_target = '0;
  logic [31:0] ld_value = '0, ld_mask = '0;
  logic        retire = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] mdl [32];
  logic [4:0]  p_tgt;
  logic [31:0] p_val, p_mask;

  always #(CLK_PERIOD/2) clk = ~clk;

  dlrf_top dut (
    .clk(clk), .rst(rst), .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .ld_en(ld_en),
    .ld_target(ld_target), .ld_value(ld_value), .ld_mask(ld_mask),
    .retire(retire)
  );

  function automatic logic [31:0] merge(input logic [31:0] old_v, v, m);
    return (old_v & ~m) | (v & m);
  endfunction

  function automatic logic [31:0] expect_rd(input logic [4:0] a);
    return (a == 5'd0) ? 32'd0 : mdl[a];
  endfunction

  task automatic model_update();
    if (rst) begin
      for (int i = 0; i < 32; i++) mdl[i] = '0;
      p_tgt = '0; p_val = '0; p_mask = '0;
    end else begin
      if (wr_en && wr_addr != 5'd0) mdl[wr_addr] = wr_data;
      if ((ld_en || retire) && p_tgt != 5'd0)
        mdl[p_tgt] = merge(mdl[p_tgt], p_val, p_mask);
      if (ld_en) begin
        p_tgt = ld_target; p_val = ld_value; p_mask = ld_mask;
      end else if (retire) begin
        p_tgt = '0; p_val = '0; p_mask = '0;
      end
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_update();
    @(negedge clk);
    wr_en = 1'b0; ld_en = 1'b0; retire = 1'b0;
  endtask

  task automatic chk(input string req, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd2(input logic [4:0] a, b, input string req);
    rd_addr_a = a; rd_addr_b = b;
    #1;
    chk(req, rd_data_a, expect_rd(a));
    chk(req, rd_data_b, expect_rd(b));
  endtask

  task automatic rd_lit(input logic [4:0] a, input logic [31:0] exp, input string req);
    rd_addr_a = a; rd_addr_b = a;
    #1;
    chk(req, rd_data_a, exp);
    chk({req, "_portB"}, rd_data_b, exp);
  endtask

  task automatic do_write(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
  endtask

  task automatic do_load(input logic [4:0] t, input logic [31:0] v, m);
    ld_en = 1'b1; ld_target = t; ld_value = v; ld_mask = m;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd20240611);
    @(negedge clk);
    tick(); rst = 1'b1; tick(); rst = 1'b0;

    // R3: every register reads zero after reset
    for (int i = 0; i < 32; i++) rd_lit(5'(i), 32'd0, "R3");

    // R1, R2: writes to register zero are dropped
    do_write(5'd0, 32'hFFFF_FFFF); tick();
    rd_lit(5'd0, 32'd0, "R1");
    do_write(5'd5, 32'hA5A5_A5A5); tick();
    rd_lit(5'd5, 32'hA5A5_A5A5, "R2");

    // R4: the scheduled load is not visible before the advance event
    do_load(5'd5, 32'h1234_5678, 32'h0000_FFFF); tick();
    rd_lit(5'd5, 32'hA5A5_A5A5, "R4");
    tick();
    rd_lit(5'd5, 32'hA5A5_A5A5, "R4_idle");
    // R5: masked merge on retire
    retire = 1'b1; tick();
    rd_lit(5'd5, 32'hA5A5_5678, "R5");

    // R7: a second retire writes nothing
    do_write(5'd5, 32'h1111_1111); tick();
    retire = 1'b1; tick();
    rd_lit(5'd5, 32'h1111_1111, "R7");

    // R6: back-to-back schedules commit the first one only
    do_load(5'd6, 32'h0000_00AA, 32'h0000_00FF); tick();
    do_load(5'd7, 32'hBB00_0000, 32'hFF00_0000); tick();
    rd_lit(5'd6, 32'h0000_00AA, "R6_first");
    rd_lit(5'd7, 32'h0000_0000, "R6_second_pending");
    retire = 1'b1; tick();
    rd_lit(5'd7, 32'hBB00_0000, "R6_second_commit");

    // R8: a load aimed at register zero changes nothing
    do_load(5'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF); tick();
    retire = 1'b1; tick();
    rd_lit(5'd0, 32'd0, "R8_zero");
    for (int i = 0; i < 32; i += 2) rd2(5'(i), 5'(i + 1), "R8");

    // R9: a write and a commit to the same register in one cycle
    do_load(5'd9, 32'hFFFF_0000, 32'hFF00_FF00); tick();
    do_write(5'd9, 32'h1234_5678); retire = 1'b1; tick();
    rd_lit(5'd9, 32'hFF34_0078, "R9");

    // R10: the two ports read different addresses
    rd_addr_a = 5'd5; rd_addr_b = 5'd7; #1;
    chk("R10_a", rd_data_a, 32'h1111_1111);
    chk("R10_b", rd_data_b, 32'hBB00_0000);

    // Random mix, collisions of R9 included
    for (int n = 0; n < 600; n++) begin
      wr_en     = ($urandom % 3) == 0;
      wr_addr   = 5'($urandom % 8);
      wr_data   = $urandom;
      ld_en     = ($urandom % 3) == 0;
      ld_target = 5'($urandom % 8);
      ld_value  = $urandom;
      ld_mask   = ($urandom % 2) ? 32'h0000_00FF << (8 * ($urandom % 4)) : $urandom;
      retire    = ($urandom % 2) == 0;
      tick();
      rd2(5'($urandom % 8), 5'($urandom % 8), "R9_R5_random");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule